// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the control unit for a datapath built around a single shared internal bus. A step counter, decoded one-hot into step lines, is combined with one-hot instruction lines decoded from the opcode in the instruction register. The negative status flag also feeds in. Every gating signal of the datapath is a sum of products over these lines.

Each instruction starts with the same three fetch steps, then runs its own execute steps. The block covers four behaviours: add-from-memory, unconditional jump, jump-if-negative, and a short path for any unknown opcode. A step that waits for memory holds the counter until the memory reports completion. The end-of-instruction signal is itself a sum of step and instruction terms, and it sends the counter back to step 1.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While rst_n is low, and for the first clock cycle after it is released, every output is 0. The cycle after that is step 1.
- R2: Steps 1 to 3 of every instruction drive these signals, with all others at 0:
  - step 1: pc_out, mar_in, mem_rd, carry_in, alu_add, z_in
  - step 2: z_out, pc_in, wait_mfc
  - step 3: mdr_out, ir_in
  - exactly one step line is active at any time.
- R3: A step that asserts wait_mfc repeats, unchanged, in every cycle where mem_done is low. The step advances at the first clock edge where mem_done is high.
- R4: The opcode is ir[11:8]. Opcode 4'h1 is add-from-memory, with its source register field in ir[7:4] and its destination register field in ir[3:0]. Its steps are:
  - step 4: gpr_out, mar_in, mem_rd, with gpr_sel = source
  - step 5: gpr_out, y_in, wait_mfc, with gpr_sel = destination
  - step 6: mdr_out, z_in, alu_add
  - step 7: gpr_in, z_out, step_end, with gpr_sel = destination
  - gpr_sel is 0 in every cycle where neither gpr_out nor gpr_in is active.
  - flag_n has no effect on this instruction.
- R5: Opcode 4'h2 is an unconditional jump:
  - step 4: pc_out, y_in
  - step 5: off_out, alu_add, z_in
  - step 6: pc_in, z_out, step_end
  - flag_n has no effect on this instruction.
- R6: Opcode 4'h3 with flag_n = 1 follows the jump sequence of R5 and ends at step 6.
- R7: Opcode 4'h3 with flag_n = 0 ends at step 4, driving only pc_out, y_in and step_end.
- R8: Any other opcode drives only step_end at step 4.
- R9: The cycle after step_end is step 1 of the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 12 | Instruction register contents |
| flag_n | input | 1 | Negative status flag |
| mem_done | input | 1 | Memory function complete |
| pc_out | output | 1 | Gate PC onto bus |
| pc_in | output | 1 | Load PC from bus |
| mar_in | output | 1 | Load memory address register |
| mem_rd | output | 1 | Start memory read |
| carry_in | output | 1 | ALU carry-in set (increment) |
| alu_add | output | 1 | ALU function select add |
| z_in | output | 1 | Load Z from ALU |
| z_out | output | 1 | Gate Z onto bus |
| mdr_out | output | 1 | Gate memory data register onto bus |
| ir_in | output | 1 | Load instruction register |
| y_in | output | 1 | Load Y from bus |
| gpr_out | output | 1 | Gate selected general register onto bus |
| gpr_in | output | 1 | Load selected general register |
| gpr_sel | output | 4 | General register address |
| off_out | output | 1 | Gate instruction offset field onto bus |
| wait_mfc | output | 1 | Step waits for memory completion |
| step_end | output | 1 | Last step of instruction |

## Verification
The assertions assume that the ir value stays fixed from step 4 to the end of each instruction. They also assume that flag_n does not change within an instruction, and that mem_done only matters during steps that assert wait_mfc. The stimulus writes ir and flag_n only in the first cycle of step 1. It raises mem_done only in the last cycle of each wait step, after zero or more low cycles, so every sequence it drives stays inside these assumptions.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADDM = 4'h1,
    OPC_JMP  = 4'h2,
    OPC_JNEG = 4'h3
  } opc_e;

  // one-hot instruction lines
  typedef struct packed {
    logic addm;
    logic jmp;
    logic jneg;
    logic other;
  } ins_t;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mem_rd;
    logic carry_in;
    logic alu_add;
    logic z_in;
    logic z_out;
    logic mdr_out;
    logic ir_in;
    logic y_in;
    logic gpr_out;
    logic gpr_in;
    logic off_out;
    logic wait_mfc;
    logic step_end;
  } ctl_t;
endpackage

// File: rtl/hwc_step_counter.sv
module hwc_step_counter #(
  parameter int NSTEP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [NSTEP-1:0] t
);
  localparam int CW = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(NSTEP - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)           cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NSTEP; i++) begin : g_dec
    assign t[i] = (cnt_q == CW'(i));
  end

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(t));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(t));
endmodule

// File: rtl/hwc_instr_decoder.sv
module hwc_instr_decoder
  import hwc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ins_t             ins
);
  always_comb begin
    ins = '0;
    case (opc_e'(opc))
      OPC_ADDM: ins.addm  = 1'b1;
      OPC_JMP:  ins.jmp   = 1'b1;
      OPC_JNEG: ins.jneg  = 1'b1;
      default:  ins.other = 1'b1;
    endcase
  end
endmodule

// File: rtl/hwc_encoder.sv
module hwc_encoder
  import hwc_pkg::*;
#(
  parameter int NSTEP = 7,
  parameter int RA_W  = 4
) (
  input  logic [NSTEP-1:0] t,
  input  ins_t             ins,
  input  logic             flag_n,
  input  logic             armed,
  input  logic [RA_W-1:0]  src,
  input  logic [RA_W-1:0]  dst,
  output ctl_t             ctl,
  output logic [RA_W-1:0]  gpr_sel
);
  ctl_t raw;
  logic jump_any;

  assign jump_any = ins.jmp | ins.jneg;

  // sum-of-products per control line; t[k] is step k+1
  always_comb begin
    raw          = '0;
    raw.pc_out   = t[0] | (t[3] & jump_any);
    raw.pc_in    = t[1] | (t[5] & jump_any);
    raw.mar_in   = t[0] | (t[3] & ins.addm);
    raw.mem_rd   = t[0] | (t[3] & ins.addm);
    raw.carry_in = t[0];
    raw.alu_add  = t[0] | (t[5] & ins.addm) | (t[4] & jump_any);
    raw.z_in     = t[0] | (t[5] & ins.addm) | (t[4] & jump_any);
    raw.z_out    = t[1] | (t[6] & ins.addm) | (t[5] & jump_any);
    raw.mdr_out  = t[2] | (t[5] & ins.addm);
    raw.ir_in    = t[2];
    raw.y_in     = (t[4] & ins.addm) | (t[3] & jump_any);
    raw.gpr_out  = (t[3] | t[4]) & ins.addm;
    raw.gpr_in   = t[6] & ins.addm;
    raw.off_out  = t[4] & jump_any;
    raw.wait_mfc = t[1] | (t[4] & ins.addm);
    raw.step_end = (t[6] & ins.addm) | (t[5] & ins.jmp)
                 | (((t[5] & flag_n) | (t[3] & ~flag_n)) & ins.jneg)
                 | (t[3] & ins.other);
  end

  assign ctl = armed ? raw : '0;

  always_comb begin
    if (ctl.gpr_out && t[3])           gpr_sel = src;
    else if (ctl.gpr_out || ctl.gpr_in) gpr_sel = dst;
    else                                gpr_sel = '0;
  end
endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
  import hwc_pkg::*;
#(
  parameter int NSTEP = 7,
  parameter int RA_W  = 4,
  parameter int IR_W  = OPC_W + 2 * RA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir,
  input  logic            flag_n,
  input  logic            mem_done,
  output logic            pc_out,
  output logic            pc_in,
  output logic            mar_in,
  output logic            mem_rd,
  output logic            carry_in,
  output logic            alu_add,
  output logic            z_in,
  output logic            z_out,
  output logic            mdr_out,
  output logic            ir_in,
  output logic            y_in,
  output logic            gpr_out,
  output logic            gpr_in,
  output logic [RA_W-1:0] gpr_sel,
  output logic            off_out,
  output logic            wait_mfc,
  output logic            step_end
);
  logic [NSTEP-1:0] t;
  ins_t ins;
  ctl_t ctl;
  logic armed_q, armed_d, run;

  // one quiet cycle after reset release
  assign armed_d = 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign run = armed_q & ~(ctl.wait_mfc & ~mem_done);

  hwc_step_counter #(.NSTEP(NSTEP)) u_steps (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ctl.step_end), .t(t)
  );

  hwc_instr_decoder u_idec (
    .opc(ir[IR_W-1 -: OPC_W]), .ins(ins)
  );

  hwc_encoder #(.NSTEP(NSTEP), .RA_W(RA_W)) u_enc (
    .t(t), .ins(ins), .flag_n(flag_n), .armed(armed_q),
    .src(ir[2*RA_W-1:RA_W]), .dst(ir[RA_W-1:0]),
    .ctl(ctl), .gpr_sel(gpr_sel)
  );

  assign pc_out   = ctl.pc_out;
  assign pc_in    = ctl.pc_in;
  assign mar_in   = ctl.mar_in;
  assign mem_rd   = ctl.mem_rd;
  assign carry_in = ctl.carry_in;
  assign alu_add  = ctl.alu_add;
  assign z_in     = ctl.z_in;
  assign z_out    = ctl.z_out;
  assign mdr_out  = ctl.mdr_out;
  assign ir_in    = ctl.ir_in;
  assign y_in     = ctl.y_in;
  assign gpr_out  = ctl.gpr_out;
  assign gpr_in   = ctl.gpr_in;
  assign off_out  = ctl.off_out;
  assign wait_mfc = ctl.wait_mfc;
  assign step_end = ctl.step_end;

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (ctl == '0));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mfc && !mem_done) |=> wait_mfc);

  // R9
  end_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> (pc_out && mar_in && carry_in && !step_end));

  // R2
  addr_read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mar_in |-> mem_rd);

  // R3
  no_end_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_mfc && step_end));
endmodule

// File: tb/hw_ctrl_unit_test.sv
module hw_ctrl_unit_test;
  localparam int PERIOD = 10;

  localparam logic [15:0] W_T1 = 16'hBE00, W_T2 = 16'h4102, W_T3 = 16'h00C0;
  localparam logic [15:0] W_A4 = 16'h3010, W_A5 = 16'h0032, W_A6 = 16'h0680;
  localparam logic [15:0] W_A7 = 16'h0109, W_B4 = 16'h8020, W_B5 = 16'h0604;
  localparam logic [15:0] W_B6 = 16'h4101, W_N4 = 16'h8021, W_U4 = 16'h0001;

  logic clk = 1'b0;
  logic rst_n, flag_n, mem_done;
  logic [11:0] ir;
  logic pc_out, pc_in, mar_in, mem_rd, carry_in, alu_add, z_in, z_out;
  logic mdr_out, ir_in, y_in, gpr_out, gpr_in, off_out, wait_mfc, step_end;
  logic [3:0] gpr_sel;

  always #(PERIOD/2) clk = ~clk;

  hw_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .flag_n(flag_n), .mem_done(mem_done),
    .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_rd(mem_rd),
    .carry_in(carry_in), .alu_add(alu_add), .z_in(z_in), .z_out(z_out),
    .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .gpr_out(gpr_out),
    .gpr_in(gpr_in), .gpr_sel(gpr_sel), .off_out(off_out),
    .wait_mfc(wait_mfc), .step_end(step_end)
  );

  wire [15:0] obs = {pc_out, pc_in, mar_in, mem_rd, carry_in, alu_add, z_in, z_out,
                     mdr_out, ir_in, y_in, gpr_out, gpr_in, off_out, wait_mfc, step_end};

  typedef struct {
    logic [15:0] w;
    logic [3:0]  sel;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // monitor: one expected item per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (obs !== e.w || gpr_sel !== e.sel) begin
        bad++;
        $display("FAIL %s: word=%h sel=%h expected word=%h sel=%h",
                 e.tag, obs, gpr_sel, e.w, e.sel);
      end
    end
  end

  task automatic cyc(logic [15:0] w, logic [3:0] sel, logic mfc, string tag);
    @(posedge clk); #1;
    mem_done = mfc;
    q.push_back('{w: w, sel: sel, tag: tag});
  endtask

  task automatic exec(logic [3:0] op, logic n, logic [3:0] s, logic [3:0] d,
                      int wt, string tg);
    @(posedge clk); #1;
    ir = {op, s, d};
    flag_n = n;
    mem_done = 1'b0;
    q.push_back('{w: W_T1, sel: 4'h0, tag: "R9"});
    for (int k = 0; k < wt; k++) cyc(W_T2, 4'h0, 1'b0, "R3");
    cyc(W_T2, 4'h0, 1'b1, "R2");
    cyc(W_T3, 4'h0, 1'b0, "R2");
    case (op)
      4'h1: begin
        cyc(W_A4, s, 1'b0, tg);
        for (int k = 0; k < wt; k++) cyc(W_A5, d, 1'b0, "R3");
        cyc(W_A5, d, 1'b1, tg);
        cyc(W_A6, 4'h0, 1'b0, tg);
        cyc(W_A7, d, 1'b0, tg);
      end
      4'h2: begin
        cyc(W_B4, 4'h0, 1'b0, tg);
        cyc(W_B5, 4'h0, 1'b0, tg);
        cyc(W_B6, 4'h0, 1'b0, tg);
      end
      4'h3: begin
        if (n) begin
          cyc(W_B4, 4'h0, 1'b0, tg);
          cyc(W_B5, 4'h0, 1'b0, tg);
          cyc(W_B6, 4'h0, 1'b0, tg);
        end else begin
          cyc(W_N4, 4'h0, 1'b0, tg);
        end
      end
      default: cyc(W_U4, 4'h0, 1'b0, tg);
    endcase
  endtask

  initial begin
    rst_n = 1'b0; ir = '0; flag_n = 1'b0; mem_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (obs !== 16'h0 || gpr_sel !== 4'h0) begin
      bad++;
      $display("FAIL R1: word=%h sel=%h expected word=0000 sel=0", obs, gpr_sel);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    q.push_back('{w: 16'h0, sel: 4'h0, tag: "R1"});

    exec(4'h1, 1'b1, 4'h3, 4'h1, 0, "R4");
    exec(4'h1, 1'b0, 4'hA, 4'h5, 2, "R4");
    exec(4'h2, 1'b0, 4'h7, 4'h2, 0, "R5");
    exec(4'h2, 1'b1, 4'h7, 4'h2, 1, "R5");
    exec(4'h3, 1'b1, 4'h0, 4'h0, 0, "R6");
    exec(4'h3, 1'b0, 4'h0, 4'h0, 3, "R7");
    exec(4'hA, 1'b1, 4'h1, 4'h1, 0, "R8");
    exec(4'h0, 1'b0, 4'h2, 4'h2, 0, "R8");
    exec(4'h1, 1'b0, 4'hF, 4'h0, 1, "R4");

    @(posedge clk); #1;
    q.push_back('{w: W_T1, sel: 4'h0, tag: "R9"});
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule